// File: doc/BRIEF.md
# Slow-Tick Match Timer

This block is a bus-programmed 32-bit event timer. An event counter advances by one on each cycle where the slow tick-enable input is high. The tick input stands for a 32768 Hz domain that is sampled by the fast bus clock. When the count becomes equal to a programmed match value while counting is enabled, the block emits a one-cycle interrupt pulse. Software can use the timer in two ways. In one-shot use, software turns the timer off after the interrupt. In periodic use, the clear-on-match option makes the counter return to zero on the tick that follows a match.

A write to the clear register does not zero the counter at once. The request stays pending until the next slow tick applies it, and a status flag shows the pending state so that software can poll for completion. A second counter runs on the fast clock through a prescaler that divides by 1 to 4. It serves as a free-running, readable time source that wraps modulo 2^32.

The event counter is governed by a three-state machine:
- `ST_IDLE`: counting is disabled.
- `ST_COUNT`: the counter advances on ticks.
- `ST_CLR_PEND`: a clear is waiting for a tick.

The transitions are:
- `ENABLE`: IDLE to COUNT, when control bit 0 is set.
- `DISABLE`: COUNT to IDLE, when bit 0 is cleared.
- `CLEAR_REQ`: any state to CLR_PEND, on a write to the clear register.
- `CLEAR_DONE`: CLR_PEND to COUNT or to IDLE, according to bit 0, on the next tick with no new clear write.

Top module: `match_timer`

Register byte offsets:

| Offset | Register | Contents |
|---|---|---|
| 0x00 | match | match value |
| 0x04 | count | live event count |
| 0x08 | control | bit 0 enable, bit 1 clear-on-match |
| 0x0C | clear | write-only strobe |
| 0x10 | divider | bits [1:0] divider code, bit 8 source enable |
| 0x14 | status | bit 10 clear pending |
| 0x18 | source | free-running source count |

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: With control bit 0 (offset 0x08) set, the count at 0x04 rises by exactly one for each slow tick. With bit 0 clear, the count holds through any number of ticks.
- R3: When the count becomes equal to the match value at 0x00 while bit 0 is set, `irq_o` is high for exactly one clock cycle.
- R4: While bit 0 is clear, no interrupt pulse is produced, even when the count equals the match value.
- R5: With control bit 1 set, the tick after a match returns the count to zero and counting continues, so the interrupt repeats once per period.
- R6: With control bit 1 clear, the count runs past the match value and no second interrupt occurs on the following ticks.
- R7: A write of any data to 0x0C sets status bit 10 at 0x14 and leaves the count unchanged until the next tick. That tick zeroes the count and drops the flag.
- R8: The control register reads back only bits 1:0, and the status register reads zero in every bit other than bit 10.
- R9: With divider bit 8 set, the source count at 0x18 advances once every n+1 clock cycles, where n is the code in bits [1:0]. Code 0x3 divides by 4.
- R10: With divider bit 8 clear, the source count holds. The divider register reads back bits [1:0] and bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and fast clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| slow_tick_i | input | 1 | Slow-domain tick enable |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Some properties are asserted on every cycle:
- The interrupt never lasts more than one cycle.
- The interrupt only follows a cycle with counting enabled.
- The count stays frozen while the timer is disabled with no clear pending.
- Every clear write raises the pending flag.
- The pending flag falls only together with a zero count.
- The source counter never moves by more than one per cycle and holds while it is disabled.

The directed scenarios must show the behaviours that depend on sequence and value:
- the interrupt fires exactly at the match;
- the periodic wrap repeats the interrupt;
- the counter runs on past the match with no second interrupt;
- the exact divide ratios hold;
- each register reads back as specified.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int DIV_W  = 2;

    localparam logic [ADDR_W-1:0] OFS_MATCH  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_DIV    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_SOURCE = 8'h18;

    localparam int PEND_BIT   = 10;
    localparam int SRC_EN_BIT = 8;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COUNT    = 2'd1,
        ST_CLR_PEND = 2'd2
    } evt_state_e;
endpackage

// File: rtl/mt_regs.sv
module mt_regs
    import mt_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int DVW = DIV_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] count_i,
    input  logic          pend_i,
    input  logic [DW-1:0] src_i,
    output logic [DW-1:0] match_o,
    output logic          en_o,
    output logic          com_o,
    output logic          clr_req_o,
    output logic [DVW-1:0] div_o,
    output logic          src_en_o,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0]  match_q;
    logic [1:0]     ctrl_q;
    logic [DVW-1:0] div_q;
    logic           src_en_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            match_q  <= '0;
            ctrl_q   <= '0;
            div_q    <= '0;
            src_en_q <= 1'b0;
        end else if (wr_i) begin
            unique case (addr_i)
                OFS_MATCH: match_q <= wdata_i;
                OFS_CTRL:  ctrl_q  <= wdata_i[1:0];
                OFS_DIV: begin
                    div_q    <= wdata_i[DVW-1:0];
                    src_en_q <= wdata_i[SRC_EN_BIT];
                end
                default: ;
            endcase
        end
    end

    assign clr_req_o = wr_i && (addr_i == OFS_CLEAR);
    assign match_o   = match_q;
    assign en_o      = ctrl_q[0];
    assign com_o     = ctrl_q[1];
    assign div_o     = div_q;
    assign src_en_o  = src_en_q;

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFS_MATCH:  rdata_o = match_q;
            OFS_COUNT:  rdata_o = count_i;
            OFS_CTRL:   rdata_o[1:0] = ctrl_q;
            OFS_DIV: begin
                rdata_o[DVW-1:0]   = div_q;
                rdata_o[SRC_EN_BIT] = src_en_q;
            end
            OFS_STATUS: rdata_o[PEND_BIT] = pend_i;
            OFS_SOURCE: rdata_o = src_i;
            default:    rdata_o = '0;
        endcase
    end

    // R8: status reads never expose bits outside the pending flag
    assert_status_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == OFS_STATUS) |-> ((rdata_o & ~(32'h1 << PEND_BIT)) == '0));
endmodule

// File: rtl/mt_event_fsm.sv
module mt_event_fsm
    import mt_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          en_i,
    input  logic          com_i,
    input  logic          clr_req_i,
    input  logic [DW-1:0] match_i,
    output logic [DW-1:0] count_o,
    output logic          pend_o,
    output logic          irq_o
);
    evt_state_e state_q, state_d;
    logic [DW-1:0] cnt_q;
    logic hit, hit_q, irq_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clr_req_i)  state_d = ST_CLR_PEND;
                else if (en_i)  state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (clr_req_i)  state_d = ST_CLR_PEND;
                else if (!en_i) state_d = ST_IDLE;
            end
            ST_CLR_PEND: begin
                if (!clr_req_i && tick_i) state_d = en_i ? ST_COUNT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (state_q == ST_CLR_PEND)
                cnt_q <= '0;
            else if (state_q == ST_COUNT && en_i)
                cnt_q <= (com_i && cnt_q == match_i) ? '0 : cnt_q + 1'b1;
        end
    end

    assign hit = en_i && (state_q != ST_CLR_PEND) && (cnt_q == match_i);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hit_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            hit_q <= hit;
            irq_q <= hit && !hit_q;
        end
    end

    assign count_o = cnt_q;
    assign pend_o  = (state_q == ST_CLR_PEND);
    assign irq_o   = irq_q;

    assert_irq_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_q |=> !irq_q);
    assert_irq_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_q |-> $past(en_i));
    assert_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && state_q != ST_CLR_PEND) |=> $stable(cnt_q));
    assert_clr_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_req_i |=> pend_o);
    assert_clr_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pend_o) |-> (cnt_q == '0));
endmodule

// File: rtl/mt_source.sv
module mt_source
    import mt_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int DVW = DIV_W
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           en_i,
    input  logic [DVW-1:0] div_i,
    output logic [DW-1:0]  src_o
);
    logic [DVW-1:0] pre_q;
    logic [DW-1:0]  src_q;
    logic           step;

    assign step = en_i && (pre_q >= div_i);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pre_q <= '0;
            src_q <= '0;
        end else if (en_i) begin
            pre_q <= step ? '0 : pre_q + 1'b1;
            if (step) src_q <= src_q + 1'b1;
        end
    end

    assign src_o = src_q;

    assert_src_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(src_q));
    assert_src_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_q == $past(src_q)) || (src_q == $past(src_q) + 1'b1));
endmodule

// File: rtl/match_timer.sv
module match_timer
    import mt_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int DVW = DIV_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          slow_tick_i,
    input  logic          bus_wr_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          irq_o
);
    logic [DW-1:0]  match_w, count_w, src_w;
    logic           en_w, com_w, clr_w, pend_w, src_en_w;
    logic [DVW-1:0] div_w;

    mt_regs #(.DW(DW), .AW(AW), .DVW(DVW)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .count_i(count_w), .pend_i(pend_w), .src_i(src_w),
        .match_o(match_w), .en_o(en_w), .com_o(com_w), .clr_req_o(clr_w),
        .div_o(div_w), .src_en_o(src_en_w), .rdata_o(bus_rdata_o)
    );

    mt_event_fsm #(.DW(DW)) u_evt (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(slow_tick_i), .en_i(en_w),
        .com_i(com_w), .clr_req_i(clr_w), .match_i(match_w),
        .count_o(count_w), .pend_o(pend_w), .irq_o(irq_o)
    );

    mt_source #(.DW(DW), .DVW(DVW)) u_src (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(src_en_w), .div_i(div_w), .src_o(src_w)
    );
endmodule

// File: tb/sim_match_timer.sv
module sim_match_timer;
    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic irq;
    int tests = 0, fails = 0, irq_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    match_timer u0 (.clk_i(clk), .rst_ni(rst_n), .slow_tick_i(tick), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

    always @(posedge clk) if (irq) irq_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a <= 8'h18; a += 4) begin
            rd_reg(a[7:0], d);
            check("R1 reg", d, 32'h0);
        end
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_oneshot();
        logic [31:0] d;
        wr_reg(8'h00, 32'd5);
        wr_reg(8'h08, 32'h1);
        ticks(4);
        rd_reg(8'h04, d); check("R2 count4", d, 32'd4);
        check("R3 no irq before match", irq_cnt, 0);
        ticks(1);
        rd_reg(8'h04, d); check("R2 count5", d, 32'd5);
        check("R3 irq at match", irq_cnt, 1);
        ticks(3);
        rd_reg(8'h04, d); check("R6 past match", d, 32'd8);
        check("R6 no second irq", irq_cnt, 1);
        wr_reg(8'h08, 32'h0);
        ticks(3);
        rd_reg(8'h04, d); check("R2 frozen", d, 32'd8);
        wr_reg(8'h00, 32'd8);
        repeat (4) @(negedge clk);
        check("R4 no irq disabled", irq_cnt, 1);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr_reg(8'h0C, 32'hFFFF_FFFF);
        rd_reg(8'h14, d); check("R7 pending set", d, 32'h400);
        rd_reg(8'h04, d); check("R7 count held", d, 32'd8);
        ticks(1);
        rd_reg(8'h04, d); check("R7 zeroed", d, 32'd0);
        rd_reg(8'h14, d); check("R7 pending drop", d, 32'h0);
    endtask

    task automatic t_periodic();
        logic [31:0] d;
        int base;
        base = irq_cnt;
        wr_reg(8'h00, 32'd3);
        wr_reg(8'h08, 32'h3);
        ticks(3);
        check("R5 first irq", irq_cnt, base + 1);
        ticks(1);
        rd_reg(8'h04, d); check("R5 wrap to zero", d, 32'd0);
        ticks(3);
        rd_reg(8'h04, d); check("R5 runs on", d, 32'd3);
        check("R5 repeat irq", irq_cnt, base + 2);
        wr_reg(8'h08, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr_reg(8'h08, 32'hFFFF_FFFF);
        rd_reg(8'h08, d); check("R8 ctrl bits", d, 32'h3);
        wr_reg(8'h08, 32'h0);
        rd_reg(8'h14, d); check("R8 status clean", d, 32'h0);
    endtask

    task automatic t_source();
        logic [31:0] s0, s1, d;
        wr_reg(8'h10, 32'h100);
        rd_reg(8'h18, s0); repeat (9) @(negedge clk); rd_reg(8'h18, s1);
        check("R9 div1", s1 - s0, 32'd10);
        wr_reg(8'h10, 32'h103);
        rd_reg(8'h10, d); check("R10 div readback", d, 32'h103);
        repeat (4) @(negedge clk);
        rd_reg(8'h18, s0); repeat (39) @(negedge clk); rd_reg(8'h18, s1);
        check("R9 div4", s1 - s0, 32'd10);
        wr_reg(8'h10, 32'h101);
        repeat (2) @(negedge clk);
        rd_reg(8'h18, s0); repeat (19) @(negedge clk); rd_reg(8'h18, s1);
        check("R9 div2", s1 - s0, 32'd10);
        wr_reg(8'h10, 32'h003);
        rd_reg(8'h18, s0); repeat (20) @(negedge clk); rd_reg(8'h18, s1);
        check("R10 source hold", s1 - s0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_oneshot();
        t_clear();
        t_periodic();
        t_regs();
        t_source();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule